// File: doc/BRIEF.md
# Directional LED Chaser

This block moves a single lit position around a ring of LEDs, one position for each enable pulse it receives from an external slow-tick divider. Two push-button inputs set the sweep direction and also start the motion. A halt input, driven by a software-controlled output bit, freezes the ring. Once halted, the ring stays frozen until a direction button is pressed again, even after the halt bit has been cleared.

The direction and run/halt state are held in a small control register. Buttons and halt are sampled on every clock cycle, so a short press between two enable pulses is not lost. The lit pattern is held in a one-hot rotate register. On each enable edge it moves by one place in the direction held before that edge. It wraps at both ends.

Top module: `led_chaser`

## Requirements
- R1: While rst_n is low, and after it is released, led is 4'b0001. The chaser is halted and its direction is up, so enable pulses do not move it until a direction button is pressed.
- R2: led always has exactly one bit set.
- R3: led changes only on a clock edge where step_en is high, the chaser is running, and halt is low. On every other edge it holds its value.
- R4: When the direction is up, each step moves the lit bit from index k to index k+1, and from index 3 to index 0.
- R5: When the direction is down, each step moves the lit bit from index k to index k-1, and from index 0 to index 3.
- R6: halt blocks a step on the same edge. It takes priority over go_up and go_down on that edge: the chaser becomes halted and no button is taken.
- R7: After halt returns low, the chaser stays halted and enable pulses do not move led until go_up or go_down is seen.
- R8: If go_up and go_down are high on the same edge, the direction becomes up.
- R9: A button is taken on any clock edge, including edges without step_en. The next enable pulse then moves led in the selected direction.
- R10: A step uses the run state and direction held before its edge. A press does not move the lit bit. A press on the same edge as step_en changes the direction from the following step onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Single-cycle advance pulse from the tick divider |
| go_up | input | 1 | Button: run toward higher index |
| go_down | input | 1 | Button: run toward lower index |
| halt | input | 1 | Software stop bit, active high |
| led | output | NUM_LEDS | One-hot LED pattern |

## Verification
A wrong run flag appears at the next enable pulse. Either led moves while it should hold, or it holds while it should move. A wrong direction flag appears in that same step, as a rotation the wrong way. A corrupted pattern register shows at once as a value with zero or several bits set. It can also show as a position that differs from the one predicted by counting steps modulo four. In every case the error is visible no later than the first enable pulse after the state goes wrong.

// File: rtl/led_chaser_pkg.sv
package led_chaser_pkg;
   typedef enum logic {
      SWEEP_DOWN = 1'b0,
      SWEEP_UP   = 1'b1
   } sweep_dir_e;

   typedef struct packed {
      logic       run;
      sweep_dir_e dir;
   } chase_state_t;
endpackage

// File: rtl/chaser_mode_ctrl.sv
module chaser_mode_ctrl
   import led_chaser_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go_up,
   input  logic         go_down,
   input  logic         halt,
   output chase_state_t state_q
);
   chase_state_t state_d;

   always_comb begin
      state_d = state_q;
      if (halt) begin
         state_d.run = 1'b0;
      end else if (go_up) begin
         state_d.run = 1'b1;
         state_d.dir = SWEEP_UP;
      end else if (go_down) begin
         state_d.run = 1'b1;
         state_d.dir = SWEEP_DOWN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q.run <= 1'b0;
         state_q.dir <= SWEEP_UP;
      end else begin
         state_q <= state_d;
      end
   end
endmodule

// File: rtl/chaser_ring.sv
module chaser_ring #(
   parameter int NUM_LEDS  = 4,
   parameter int START_POS = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                advance,
   input  logic                dir_up,
   output logic [NUM_LEDS-1:0] led_q
);
   localparam logic [NUM_LEDS-1:0] RESET_PAT = NUM_LEDS'(1) << START_POS;

   logic [NUM_LEDS-1:0] rot_up;
   logic [NUM_LEDS-1:0] rot_dn;

   for (genvar i = 0; i < NUM_LEDS; i++) begin : g_rot
      localparam int BELOW = (i + NUM_LEDS - 1) % NUM_LEDS;
      localparam int ABOVE = (i + 1) % NUM_LEDS;
      assign rot_up[i] = led_q[BELOW];
      assign rot_dn[i] = led_q[ABOVE];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         led_q <= RESET_PAT;
      end else if (advance) begin
         led_q <= dir_up ? rot_up : rot_dn;
      end
   end
endmodule

// File: rtl/led_chaser.sv
module led_chaser
   import led_chaser_pkg::*;
#(
   parameter int NUM_LEDS  = 4,
   parameter int START_POS = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step_en,
   input  logic                go_up,
   input  logic                go_down,
   input  logic                halt,
   output logic [NUM_LEDS-1:0] led
);
   if (NUM_LEDS < 2) begin : g_bad_width
      $error("led_chaser: NUM_LEDS must be at least 2");
   end
   if (START_POS < 0 || START_POS >= NUM_LEDS) begin : g_bad_start
      $error("led_chaser: START_POS out of range");
   end

   chase_state_t st_q;
   logic         advance;

   chaser_mode_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_up   (go_up),
      .go_down (go_down),
      .halt    (halt),
      .state_q (st_q)
   );

   assign advance = step_en && st_q.run && !halt;

   chaser_ring #(
      .NUM_LEDS  (NUM_LEDS),
      .START_POS (START_POS)
   ) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .dir_up  (st_q.dir == SWEEP_UP),
      .led_q   (led)
   );
endmodule

// File: rtl/led_chaser_chk.sv
module led_chaser_chk #(
   parameter int NUM_LEDS = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                step_en,
   input logic                halt,
   input logic                run_q,
   input logic                up_q,
   input logic [NUM_LEDS-1:0] led
);
   // R2
   one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(led) == 1);

   // R3
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(led));

   // R6
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> ($stable(led) && !run_q));

   // R4
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !halt && run_q && up_q) |=>
         led == {$past(led[NUM_LEDS-2:0]), $past(led[NUM_LEDS-1])});

   // R5
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !halt && run_q && !up_q) |=>
         led == {$past(led[0]), $past(led[NUM_LEDS-1:1])});

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> $stable(led));
endmodule

bind led_chaser led_chaser_chk #(.NUM_LEDS(NUM_LEDS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .step_en (step_en),
   .halt    (halt),
   .run_q   (st_q.run),
   .up_q    (st_q.dir == led_chaser_pkg::SWEEP_UP),
   .led     (led)
);

// File: tb/led_chaser_bench.sv
module led_chaser_bench;
   logic       clk = 1'b0;
   logic       rst_n, step_en, go_up, go_down, halt;
   logic [3:0] led;
   int         errors = 0;
   int         checks = 0;
   int         m_pos = 0;
   bit         m_run = 1'b0;
   bit         m_up = 1'b1;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   led_chaser u_led_chaser (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .go_up(go_up),
      .go_down(go_down), .halt(halt), .led(led)
   );

   function automatic logic [3:0] exp_led();
      return 4'(1 << m_pos);
   endfunction

   task automatic check_led(input string req, input logic [3:0] exp);
      checks++;
      if (led !== exp) begin
         errors++;
         $display("FAIL %s: led=%b expected %b", req, led, exp);
      end
   endtask

   task automatic apply(input bit en, input bit u, input bit d, input bit h);
      @(negedge clk);
      step_en = en; go_up = u; go_down = d; halt = h;
      @(posedge clk);
      if (en && m_run && !h) m_pos = m_up ? (m_pos + 1) % 4 : (m_pos + 3) % 4;
      if (h) m_run = 1'b0;
      else if (u) begin m_run = 1'b1; m_up = 1'b1; end
      else if (d) begin m_run = 1'b1; m_up = 1'b0; end
      #2;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; step_en = 0; go_up = 0; go_down = 0; halt = 0;
      repeat (2) @(posedge clk);
      #2;
      check_led("R1", 4'b0001);
      @(negedge clk);
      rst_n = 1'b1;
      m_pos = 0; m_run = 1'b0; m_up = 1'b1;
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      report();
   end

   initial begin
      logic [7:0] lfsr;
      rst_n = 1'b0; step_en = 0; go_up = 0; go_down = 0; halt = 0;
      do_reset();
      apply(0, 0, 0, 0); check_led("R1", 4'b0001);
      apply(1, 0, 0, 0); check_led("R1", 4'b0001);
      // R9: press between ticks, then tick
      apply(0, 1, 0, 0); check_led("R9", 4'b0001);
      apply(1, 0, 0, 0); check_led("R9", 4'b0010);
      apply(1, 0, 0, 0); check_led("R4", 4'b0100);
      apply(1, 0, 0, 0); check_led("R4", 4'b1000);
      apply(1, 0, 0, 0); check_led("R4", 4'b0001);
      apply(0, 0, 0, 0); check_led("R3", 4'b0001);
      // R10: reversal keeps position
      apply(0, 0, 1, 0); check_led("R10", 4'b0001);
      apply(1, 0, 0, 0); check_led("R5", 4'b1000);
      apply(1, 0, 0, 0); check_led("R5", 4'b0100);
      apply(1, 1, 0, 0); check_led("R10", 4'b0010);
      apply(1, 0, 0, 0); check_led("R10", 4'b0100);
      // R6 / R7
      apply(1, 1, 1, 1); check_led("R6", 4'b0100);
      apply(1, 0, 0, 0); check_led("R7", 4'b0100);
      apply(1, 0, 0, 0); check_led("R7", 4'b0100);
      // R8
      apply(0, 1, 1, 0); check_led("R8", 4'b0100);
      apply(1, 0, 0, 0); check_led("R8", 4'b1000);
      // pseudo-random sweep against the arithmetic model
      lfsr = 8'hA5;
      for (int i = 0; i < 800; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         apply(lfsr[2] | lfsr[6], lfsr[0] & lfsr[3], lfsr[1] & lfsr[4],
               lfsr[7:5] == 3'b000);
         checks++;
         if ($countones(led) != 1) begin
            errors++;
            $display("FAIL R2: led=%b expected one bit set", led);
         end
         check_led("R3", exp_led());
      end
      // reset while running
      apply(0, 1, 0, 0);
      do_reset();
      apply(1, 0, 0, 0); check_led("R1", 4'b0001);
      report();
   end
endmodule